// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block resolves read-after-write data hazards for the instruction in the execute stage of a five-stage, in-order pipeline. For each source operand it compares the source register number against the destination registers of the two older instructions still in flight: the one in the memory stage and the one in writeback. If an older instruction will write that register, the block passes the newer value to execute in place of the stale register-file read.

Each operand has its own 2-bit select code and its own 3:1 multiplexer. The multiplexer output is the value execute uses everywhere it needs that operand: both ALU inputs and the store-data path. The memory-stage producer is the nearer one, so it always wins over writeback. Register 0 never forwards. The block is purely combinational and has no clock.

Stalls for load-use hazards are handled by a separate controller. That controller makes sure a load in the memory stage is never chosen as a forwarding source.

Top module: `fwd_unit`

## Requirements
- R1: The select code uses this encoding: 0 means the register-file value, 1 means the writeback result and 2 means the memory-stage ALU result. Code 3 is never produced. With no matching producer the select is 0 and the operand output equals the register-file input.
- R2: When a source register is nonzero, equals `mem_dst_i` and `mem_wen_i` is 1, the select is 2 and the operand output equals `mem_alu_i`. This holds for every register number up to 31.
- R3: When a source register is nonzero, equals `wb_dst_i`, `wb_wen_i` is 1 and there is no memory-stage match, the select is 1 and the operand output equals `wb_data_i`.
- R4: When both stages match a source register, the memory stage has priority. So after writes of 3 and then 4 to the same register, the operand is 4.
- R5: A stage whose write flag is 0 never forwards, even when its destination matches.
- R6: Source register 0 never forwards. Its select is 0 and its output is the register-file input, whatever the destinations and write flags are.
- R7: The two operands are independent. Operand k uses source bits [k*5 +: 5], register-file bits [k*64 +: 64], select bits [k*2 +: 2] and output bits [k*64 +: 64]. The select of one operand never depends on the other operand's source.
- R8: Outputs follow the inputs combinationally. Example: with a1 produced by the instruction in writeback (value 3) and a2 produced by the instruction in the memory stage (value 4), an add of a1 and a2 in execute sees operands that sum to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_i | input | NUM_SRC*REG_AW | Source register numbers of the instruction in execute |
| ex_rfval_i | input | NUM_SRC*XLEN | Register-file operand values latched for execute |
| mem_dst_i | input | REG_AW | Destination register of the instruction in the memory stage |
| mem_wen_i | input | 1 | Register-write flag of the instruction in the memory stage |
| mem_alu_i | input | XLEN | ALU result held in the memory stage |
| wb_dst_i | input | REG_AW | Destination register of the instruction in writeback |
| wb_wen_i | input | 1 | Register-write flag of the instruction in writeback |
| wb_data_i | input | XLEN | Writeback result-multiplexer value |
| fwd_sel_o | output | NUM_SRC*2 | Per-operand select code |
| opnd_o | output | NUM_SRC*XLEN | Per-operand forwarded value |

## Verification
The bench sweeps every combination of register numbers 0 to 3 on both sources and both destinations, under all four write-flag combinations. This covers the case where both stages match at once, where priority inverted would deliver the older writeback value. It also covers a matching destination with its write flag clear, which a careless design forwards anyway, and register 0 named as a destination, which a design without the zero guard would forward as a nonzero value. Directed cases at register 31 and the add of 3 plus 4 catch truncated comparators and swapped operand slices, because a wrong slice would cross-feed one operand's value into the other.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      FWD_RF  = 2'd0,
      FWD_WB  = 2'd1,
      FWD_MEM = 2'd2
   } fwd_sel_e;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic [REG_AW-1:0] dst_i,
   input  logic              wen_i,
   output logic              hit_o
);

   logic same;
   assign same = (src_i == dst_i);

   generate
      if (ZERO_GUARD) begin : g_guard
         // register 0 is hard-wired, so it never takes a forwarded value
         assign hit_o = wen_i & same & (|src_i);
      end else begin : g_plain
         assign hit_o = wen_i & same;
      end
   endgenerate

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
(
   input  logic     mem_hit_i,
   input  logic     wb_hit_i,
   output fwd_sel_e sel_o
);

   always_comb begin
      if (mem_hit_i)     sel_o = FWD_MEM;   // nearer producer first
      else if (wb_hit_i) sel_o = FWD_WB;
      else               sel_o = FWD_RF;
   end

endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  fwd_sel_e          sel_i,
   input  logic [XLEN-1:0]   rf_i,
   input  logic [XLEN-1:0]   mem_i,
   input  logic [XLEN-1:0]   wb_i,
   output logic [XLEN-1:0]   out_o
);

   always_comb begin
      unique case (sel_i)
         FWD_MEM: out_o = mem_i;
         FWD_WB:  out_o = wb_i;
         default: out_o = rf_i;
      endcase
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 2,
   parameter int unsigned REG_AW     = 5,
   parameter int unsigned XLEN       = 64,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [NUM_SRC*REG_AW-1:0] ex_src_i,
   input  logic [NUM_SRC*XLEN-1:0]   ex_rfval_i,
   input  logic [REG_AW-1:0]         mem_dst_i,
   input  logic                      mem_wen_i,
   input  logic [XLEN-1:0]           mem_alu_i,
   input  logic [REG_AW-1:0]         wb_dst_i,
   input  logic                      wb_wen_i,
   input  logic [XLEN-1:0]           wb_data_i,
   output logic [NUM_SRC*SEL_W-1:0]  fwd_sel_o,
   output logic [NUM_SRC*XLEN-1:0]   opnd_o
);

   localparam int unsigned SRC_BITS = NUM_SRC * REG_AW;

   generate
      if (NUM_SRC < 1)   begin : g_bad_src  $error("fwd_unit: NUM_SRC must be at least 1"); end
      if (REG_AW < 1)    begin : g_bad_aw   $error("fwd_unit: REG_AW must be at least 1"); end
      if (XLEN < 1)      begin : g_bad_xlen $error("fwd_unit: XLEN must be at least 1"); end
      if (SRC_BITS > 1024) begin : g_bad_sz $error("fwd_unit: source bus too wide"); end
   endgenerate

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_op
      logic     mem_hit;
      logic     wb_hit;
      fwd_sel_e sel;

      fwd_match #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_mem_cmp (
         .src_i (ex_src_i[k*REG_AW +: REG_AW]),
         .dst_i (mem_dst_i),
         .wen_i (mem_wen_i),
         .hit_o (mem_hit)
      );

      fwd_match #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_wb_cmp (
         .src_i (ex_src_i[k*REG_AW +: REG_AW]),
         .dst_i (wb_dst_i),
         .wen_i (wb_wen_i),
         .hit_o (wb_hit)
      );

      fwd_pick u_pick (
         .mem_hit_i (mem_hit),
         .wb_hit_i  (wb_hit),
         .sel_o     (sel)
      );

      fwd_mux #(.XLEN(XLEN)) u_mux (
         .sel_i (sel),
         .rf_i  (ex_rfval_i[k*XLEN +: XLEN]),
         .mem_i (mem_alu_i),
         .wb_i  (wb_data_i),
         .out_o (opnd_o[k*XLEN +: XLEN])
      );

      assign fwd_sel_o[k*SEL_W +: SEL_W] = sel;
   end

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int unsigned NUM_SRC    = 2,
   parameter int unsigned REG_AW     = 5,
   parameter int unsigned XLEN       = 64,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input logic [NUM_SRC*REG_AW-1:0] ex_src_i,
   input logic [NUM_SRC*XLEN-1:0]   ex_rfval_i,
   input logic [REG_AW-1:0]         mem_dst_i,
   input logic                      mem_wen_i,
   input logic [XLEN-1:0]           mem_alu_i,
   input logic [REG_AW-1:0]         wb_dst_i,
   input logic                      wb_wen_i,
   input logic [XLEN-1:0]           wb_data_i,
   input logic [NUM_SRC*2-1:0]      fwd_sel_o,
   input logic [NUM_SRC*XLEN-1:0]   opnd_o
);

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_c
      logic [1:0]        s;
      logic [REG_AW-1:0] r;
      logic [XLEN-1:0]   v;
      logic [XLEN-1:0]   f;
      assign s = fwd_sel_o[k*2 +: 2];
      assign r = ex_src_i[k*REG_AW +: REG_AW];
      assign f = ex_rfval_i[k*XLEN +: XLEN];
      assign v = opnd_o[k*XLEN +: XLEN];

      always_comb begin
         // R1
         sel_legal_chk: assert (s != 2'd3);
         // R1
         rf_path_chk: assert (s != 2'd0 || v == f);
         // R2
         mem_path_chk: assert (s != 2'd2 || v == mem_alu_i);
         // R3
         wb_path_chk: assert (s != 2'd1 || v == wb_data_i);
         // R4
         near_wins_chk: assert (!(mem_wen_i && r == mem_dst_i && r != '0) || s == 2'd2);
         // R5
         idle_stage_chk: assert ((mem_wen_i || s != 2'd2) && (wb_wen_i || s != 2'd1));
         // R6
         zero_src_chk: assert (!ZERO_GUARD || r != '0 || s == 2'd0);
      end
   end

endmodule

bind fwd_unit fwd_unit_chk #(
   .NUM_SRC(NUM_SRC), .REG_AW(REG_AW), .XLEN(XLEN), .ZERO_GUARD(ZERO_GUARD)
) u_chk (
   .ex_src_i   (ex_src_i),
   .ex_rfval_i (ex_rfval_i),
   .mem_dst_i  (mem_dst_i),
   .mem_wen_i  (mem_wen_i),
   .mem_alu_i  (mem_alu_i),
   .wb_dst_i   (wb_dst_i),
   .wb_wen_i   (wb_wen_i),
   .wb_data_i  (wb_data_i),
   .fwd_sel_o  (fwd_sel_o),
   .opnd_o     (opnd_o)
);

// File: tb/fwd_unit_bench.sv
`timescale 1ns/100ps
module fwd_unit_bench;

   localparam int unsigned AW = 5;
   localparam int unsigned XW = 64;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [2*AW-1:0] ex_src;
   logic [2*XW-1:0] ex_rfval;
   logic [AW-1:0]   mem_dst, wb_dst;
   logic            mem_wen, wb_wen;
   logic [XW-1:0]   mem_alu, wb_data;
   logic [3:0]      fwd_sel;
   logic [2*XW-1:0] opnd;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   fwd_unit u_fwd_unit (
      .ex_src_i(ex_src), .ex_rfval_i(ex_rfval),
      .mem_dst_i(mem_dst), .mem_wen_i(mem_wen), .mem_alu_i(mem_alu),
      .wb_dst_i(wb_dst), .wb_wen_i(wb_wen), .wb_data_i(wb_data),
      .fwd_sel_o(fwd_sel), .opnd_o(opnd)
   );

   task automatic chk(input string tag, input logic [XW-1:0] act, input logic [XW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] model_sel(input logic [AW-1:0] s);
      if (s != 0 && mem_wen && s == mem_dst) return 2'd2;
      if (s != 0 && wb_wen && s == wb_dst)   return 2'd1;
      return 2'd0;
   endfunction

   task automatic check_ops(input string tag);
      for (int k = 0; k < 2; k++) begin
         logic [1:0]    es;
         logic [XW-1:0] ev;
         es = model_sel(ex_src[k*AW +: AW]);
         ev = (es == 2'd2) ? mem_alu : (es == 2'd1) ? wb_data : ex_rfval[k*XW +: XW];
         chk({tag, " sel"}, 64'(fwd_sel[k*2 +: 2]), 64'(es));
         chk({tag, " opnd"}, opnd[k*XW +: XW], ev);
      end
   endtask

   task automatic drive(input logic [AW-1:0] s0, s1, md, wd, input logic mw, ww);
      @(posedge clk);
      ex_src  = {s1, s0};
      mem_dst = md; mem_wen = mw;
      wb_dst  = wd; wb_wen  = ww;
      @(negedge clk);
   endtask

   initial begin
      ex_src = '0; mem_dst = '0; wb_dst = '0; mem_wen = 1'b0; wb_wen = 1'b0;
      ex_rfval = {64'h0000_1111_2222_0001, 64'h0000_1111_2222_0000};
      mem_alu  = 64'hAAAA_0000_BBBB_0002;
      wb_data  = 64'h5555_0000_6666_0001;
      @(negedge clk);
      // R1 idle state: both operands pass the register file
      chk("R1 idle sel", 64'(fwd_sel), 64'd0);
      chk("R1 idle opnd", opnd, ex_rfval);

      // sweep: R1 R2 R3 R4 R5 R6 R7 over registers 0..3
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int m = 0; m < 4; m++)
               for (int w = 0; w < 4; w++)
                  for (int f = 0; f < 4; f++) begin
                     drive(AW'(a), AW'(b), AW'(m), AW'(w), f[0], f[1]);
                     check_ops("R2_R3_R4_R5_R6_R7 sweep");
                  end

      // R2 top register number
      drive(5'd31, 5'd30, 5'd31, 5'd30, 1'b1, 1'b1);
      chk("R2 reg31 opnd0", opnd[0 +: XW], mem_alu);
      chk("R3 reg30 opnd1", opnd[XW +: XW], wb_data);

      // R6 register 0 written by both stages
      drive(5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1);
      chk("R6 zero sel", 64'(fwd_sel), 64'd0);
      chk("R6 zero opnd", opnd, ex_rfval);

      // R4 writes of 3 then 4 to a0 (x10), add a0,a0,a0
      @(posedge clk);
      wb_data = 64'd3; mem_alu = 64'd4;
      drive(5'd10, 5'd10, 5'd10, 5'd10, 1'b1, 1'b1);
      chk("R4 newest opnd0", opnd[0 +: XW], 64'd4);
      chk("R4 newest opnd1", opnd[XW +: XW], 64'd4);

      // R8 li a1,3 in writeback; li a2,4 in memory; add a0,a1,a2
      drive(5'd11, 5'd12, 5'd12, 5'd11, 1'b1, 1'b1);
      chk("R8 sum", opnd[0 +: XW] + opnd[XW +: XW], 64'd7);
      chk("R7 sel split", 64'(fwd_sel), 64'b1001);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule